// File: doc/BRIEF.md
# Hold-and-filter sample rate converter

This block moves a single channel of signed audio from one arbitrary sample rate to another. Each arriving input sample is latched and held, and a fast internal tick enable repeats the held value at every tick. The result is a staircase at the tick rate. A second-order recursive low-pass filter, updated once per tick, smooths the steps away. Whenever the output-rate strobe fires, the current filtered value is rounded back to the audio width and presented with a one-cycle valid pulse.

The input rate, the tick rate and the output rate are independent. The only constraints are that ticks come faster than input samples and that all three are enables in one clock domain. The default coefficients give a Butterworth-like low-pass with its corner near one twenty-fourth of the tick rate and a DC gain of one. Callers may override them for another response, provided the feedback loop stays stable.

Top module: `hold_filter_src`

## Requirements
- R1: Synchronous reset clears the hold register, all filter state, `out_data`, `out_valid` and `overrun` to zero. A strobe issued straight after reset returns 0.
- R2: When `in_valid` is high, `in_data` is latched at that edge. Every later tick feeds that same value to the filter until another sample is latched.
- R3: Filter state changes only on edges where `tick` is high. On such an edge the new output is y = sat32((F0*x0 + F1*x1 + F2*x2 + B1*y1 + B2*y2) >>> 30), where all coefficients are signed Q2.30 and both feedback terms are added. Here x0 is the held sample sign-extended to 32 bits and multiplied by 16, x1 and x2 are the two previous x0 values, and y1 and y2 are the two previous outputs.
- R4: The filter result saturates to the 32-bit signed limits instead of wrapping, in both directions.
- R5: The output word is the filter result rounded as (y + 8) >>> 4 and then saturated to the 24-bit signed range.
- R6: `out_strobe` at an edge loads the converted current filter output into `out_data` and sets `out_valid` high for exactly that one following cycle. Without a strobe, `out_data` keeps its value.
- R7: When `out_strobe` and `tick` are high on the same edge, `out_data` takes the filter value from before that tick's update.
- R8: Two latched samples with no tick between them keep only the newer one and set `overrun`. The flag stays set until reset. A sample that arrives on the same edge as a tick is not an overrun: that tick uses the previously held value, and the new sample waits for the next tick.
- R9: With the default coefficients, a constant input held for 400 ticks gives an output within 4 LSB of that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | 24 | Signed input sample |
| tick | input | 1 | Internal fast-rate enable, one filter step |
| out_strobe | input | 1 | Output-rate sampling request |
| out_data | output | 24 | Signed resampled output |
| out_valid | output | 1 | High for one cycle after each strobe |
| overrun | output | 1 | Sticky flag: a held sample was replaced before any tick used it |

## Verification
A latched sample reaches the filter at the first tick after the latch edge. The filter value changes one edge after that tick, and a strobe moves the value to `out_data` and `out_valid` one edge after the strobe. `overrun` rises on the edge of the second unconsumed sample. The bench drives all inputs for a single edge at the falling clock and samples one falling edge later, so every result is read exactly one register stage after its cause. A cycle-level model that follows the requirements predicts the filter output, the rounding, the valid pulse and the flag. Hand-computed vectors on a pure integrator instance pin down sample holding, saturation and strobe/tick ordering.

// File: rtl/src_pkg.sv
package src_pkg;
    localparam int SAMPLE_W  = 24;
    localparam int WORD_W    = 32;
    localparam int COEF_FRAC = 30;
    localparam int NTAP      = 5;

    // Default low-pass, corner near tick_rate/24, unity DC gain (Q2.30)
    localparam logic signed [31:0] LP_FF0 = 32'sd15461614;
    localparam logic signed [31:0] LP_FF1 = 32'sd30923228;
    localparam logic signed [31:0] LP_FF2 = 32'sd15461614;
    localparam logic signed [31:0] LP_FB1 = 32'sd1753420398;
    localparam logic signed [31:0] LP_FB2 = -32'sd741525030;
endpackage

// File: rtl/src_hold.sv
module src_hold #(
    parameter int SAMPLE_W = src_pkg::SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                tick,
    output logic [SAMPLE_W-1:0] hold_val,
    output logic                overrun
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] hold;
        logic                pend;
        logic                ovr;
    } hold_st_t;

    hold_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.hold = in_data;
            st_d.pend = 1'b1;
            if (st_q.pend && !tick) begin
                st_d.ovr = 1'b1;
            end
        end else if (tick) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hold_val = st_q.hold;
    assign overrun  = st_q.ovr;

    // R2: the held sample only changes on an input edge
    p_hold_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(hold_val));

    // R8: overrun is sticky
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

// File: rtl/src_biquad.sv
module src_biquad #(
    parameter int WORD_W    = src_pkg::WORD_W,
    parameter int COEF_FRAC = src_pkg::COEF_FRAC,
    parameter logic signed [WORD_W-1:0] FF0 = WORD_W'(src_pkg::LP_FF0),
    parameter logic signed [WORD_W-1:0] FF1 = WORD_W'(src_pkg::LP_FF1),
    parameter logic signed [WORD_W-1:0] FF2 = WORD_W'(src_pkg::LP_FF2),
    parameter logic signed [WORD_W-1:0] FB1 = WORD_W'(src_pkg::LP_FB1),
    parameter logic signed [WORD_W-1:0] FB2 = WORD_W'(src_pkg::LP_FB2)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic signed [WORD_W-1:0] x_in,
    output logic signed [WORD_W-1:0] y_out
);
    localparam int NTAP   = src_pkg::NTAP;
    localparam int PROD_W = 2 * WORD_W;
    localparam int ACC_W  = PROD_W + $clog2(NTAP);
    localparam logic signed [WORD_W-1:0] COEF [NTAP] = '{FF0, FF1, FF2, FB1, FB2};
    localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'({1'b0, {(WORD_W-1){1'b1}}});
    localparam logic signed [ACC_W-1:0] Y_MIN = ~Y_MAX;

    typedef struct packed {
        logic signed [WORD_W-1:0] x1;
        logic signed [WORD_W-1:0] x2;
        logic signed [WORD_W-1:0] y1;
        logic signed [WORD_W-1:0] y2;
    } filt_st_t;

    filt_st_t st_q, st_d;

    logic signed [WORD_W-1:0] opnd [NTAP];
    logic signed [PROD_W-1:0] prod [NTAP];
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_sh;
    logic signed [WORD_W-1:0] y_new;

    always_comb begin
        opnd[0] = x_in;
        opnd[1] = st_q.x1;
        opnd[2] = st_q.x2;
        opnd[3] = st_q.y1;
        opnd[4] = st_q.y2;
    end

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        assign prod[k] = PROD_W'(opnd[k]) * PROD_W'(COEF[k]);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAP; k++) begin
            acc = acc + ACC_W'(prod[k]);
        end
        acc_sh = acc >>> COEF_FRAC;
        if (acc_sh > Y_MAX)      y_new = {1'b0, {(WORD_W-1){1'b1}}};
        else if (acc_sh < Y_MIN) y_new = {1'b1, {(WORD_W-1){1'b0}}};
        else                     y_new = WORD_W'(acc_sh);

        st_d = st_q;
        if (tick) begin
            st_d.x1 = x_in;
            st_d.x2 = st_q.x1;
            st_d.y1 = y_new;
            st_d.y2 = st_q.y1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign y_out = st_q.y1;

    // R3: no filter movement without a tick
    p_state_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(y_out));

    // R4: an over-range sum clips to the positive limit
    p_clip_high_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && acc_sh > Y_MAX) |=> (y_out == {1'b0, {(WORD_W-1){1'b1}}}));
endmodule

// File: rtl/src_outreg.sv
module src_outreg #(
    parameter int WORD_W   = src_pkg::WORD_W,
    parameter int SAMPLE_W = src_pkg::SAMPLE_W,
    parameter int SCALE    = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     strobe,
    input  logic signed [WORD_W-1:0] y_in,
    output logic [SAMPLE_W-1:0]      data,
    output logic                     valid
);
    localparam int EXT_W = WORD_W + 1;
    localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) <<< (SCALE - 1);
    localparam logic signed [EXT_W-1:0] OMAX = EXT_W'({1'b0, {(SAMPLE_W-1){1'b1}}});
    localparam logic signed [EXT_W-1:0] OMIN = ~OMAX;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                valid;
    } out_st_t;

    out_st_t st_q, st_d;
    logic signed [EXT_W-1:0] rnd;
    logic signed [EXT_W-1:0] shifted;
    logic [SAMPLE_W-1:0]     conv;

    always_comb begin
        rnd     = EXT_W'(y_in) + HALF;
        shifted = rnd >>> SCALE;
        if (shifted > OMAX)      conv = {1'b0, {(SAMPLE_W-1){1'b1}}};
        else if (shifted < OMIN) conv = {1'b1, {(SAMPLE_W-1){1'b0}}};
        else                     conv = SAMPLE_W'(shifted);

        st_d       = st_q;
        st_d.valid = strobe;
        if (strobe) begin
            st_d.data = conv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data  = st_q.data;
    assign valid = st_q.valid;

    // R6: output word holds between strobes
    p_data_held_r6: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(data));

    // R6: every strobe yields a valid pulse that ends without a new strobe
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (strobe |=> valid) and (!strobe |=> !valid));
endmodule

// File: rtl/hold_filter_src.sv
module hold_filter_src #(
    parameter int SAMPLE_W  = src_pkg::SAMPLE_W,
    parameter int WORD_W    = src_pkg::WORD_W,
    parameter int COEF_FRAC = src_pkg::COEF_FRAC,
    parameter logic signed [WORD_W-1:0] COEF_FF0 = WORD_W'(src_pkg::LP_FF0),
    parameter logic signed [WORD_W-1:0] COEF_FF1 = WORD_W'(src_pkg::LP_FF1),
    parameter logic signed [WORD_W-1:0] COEF_FF2 = WORD_W'(src_pkg::LP_FF2),
    parameter logic signed [WORD_W-1:0] COEF_FB1 = WORD_W'(src_pkg::LP_FB1),
    parameter logic signed [WORD_W-1:0] COEF_FB2 = WORD_W'(src_pkg::LP_FB2)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                tick,
    input  logic                out_strobe,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_valid,
    output logic                overrun
);
    localparam int PAD   = WORD_W - SAMPLE_W;
    localparam int SCALE = PAD / 2;
    localparam int HEAD  = PAD - SCALE;

    logic [SAMPLE_W-1:0]      hold_val;
    logic signed [WORD_W-1:0] x_word;
    logic signed [WORD_W-1:0] y_word;

    src_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .tick     (tick),
        .hold_val (hold_val),
        .overrun  (overrun)
    );

    assign x_word = {{HEAD{hold_val[SAMPLE_W-1]}}, hold_val, {SCALE{1'b0}}};

    src_biquad #(
        .WORD_W    (WORD_W),
        .COEF_FRAC (COEF_FRAC),
        .FF0       (COEF_FF0),
        .FF1       (COEF_FF1),
        .FF2       (COEF_FF2),
        .FB1       (COEF_FB1),
        .FB2       (COEF_FB2)
    ) u_filt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .x_in  (x_word),
        .y_out (y_word)
    );

    src_outreg #(
        .WORD_W   (WORD_W),
        .SAMPLE_W (SAMPLE_W),
        .SCALE    (SCALE)
    ) u_out (
        .clk    (clk),
        .rst    (rst),
        .strobe (out_strobe),
        .y_in   (y_word),
        .data   (out_data),
        .valid  (out_valid)
    );

    // R1: reset leaves all outputs quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !overrun && out_data == '0));
endmodule

// File: tb/sim_hold_filter_src.sv
module sim_hold_filter_src;
    localparam int CLK_PERIOD = 10;
    localparam logic signed [31:0] UNITY = 32'sd1073741824;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        tick = 1'b0;
    logic        out_strobe = 1'b0;
    logic [23:0] out_d0, out_d1;
    logic        out_v0, out_v1, ovr0, ovr1;

    int nchk = 0;
    int nbad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hold_filter_src u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .tick(tick), .out_strobe(out_strobe),
        .out_data(out_d0), .out_valid(out_v0), .overrun(ovr0)
    );

    // pure integrator: y = x + y1
    hold_filter_src #(
        .COEF_FF0(UNITY), .COEF_FF1(32'sd0), .COEF_FF2(32'sd0),
        .COEF_FB1(UNITY), .COEF_FB2(32'sd0)
    ) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .tick(tick), .out_strobe(out_strobe),
        .out_data(out_d1), .out_valid(out_v1), .overrun(ovr1)
    );

    // ---------------- reference model ----------------
    logic signed [31:0] mf0 [2], mf1 [2], mf2 [2], mb1 [2], mb2 [2];
    logic signed [31:0] mx1 [2], mx2 [2], my1 [2], my2 [2];
    logic signed [23:0] mout [2];
    logic        mvld, mpend, movr;
    logic [23:0] mh;

    function automatic logic signed [31:0] m_sat32(input logic signed [71:0] v);
        if (v > 72'sd2147483647)  return 32'sh7fffffff;
        if (v < -72'sd2147483648) return 32'sh80000000;
        return v[31:0];
    endfunction

    function automatic logic signed [23:0] m_conv(input logic signed [31:0] y);
        logic signed [33:0] t;
        t = (34'(y) + 34'sd8) >>> 4;
        if (t > 34'sd8388607)  return 24'sh7fffff;
        if (t < -34'sd8388608) return 24'sh800000;
        return t[23:0];
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 2; i++) begin
            mx1[i] = 0; mx2[i] = 0; my1[i] = 0; my2[i] = 0; mout[i] = 0;
        end
        mvld = 0; mpend = 0; movr = 0; mh = 0;
    endtask

    task automatic m_edge(input logic v, input logic [23:0] d, input logic t, input logic s);
        logic signed [31:0] x0;
        logic signed [71:0] acc;
        logic signed [31:0] yn;
        mvld = s;
        for (int i = 0; i < 2; i++) begin
            if (s) mout[i] = m_conv(my1[i]);
        end
        if (t) begin
            x0 = {{4{mh[23]}}, mh, 4'b0000};
            for (int i = 0; i < 2; i++) begin
                acc = 72'(mf0[i]) * 72'(x0) + 72'(mf1[i]) * 72'(mx1[i])
                    + 72'(mf2[i]) * 72'(mx2[i]) + 72'(mb1[i]) * 72'(my1[i])
                    + 72'(mb2[i]) * 72'(my2[i]);
                yn = m_sat32(acc >>> 30);
                mx2[i] = mx1[i]; mx1[i] = x0;
                my2[i] = my1[i]; my1[i] = yn;
            end
        end
        if (v) begin
            if (mpend && !t) movr = 1;
            mh = d;
            mpend = 1;
        end else if (t) begin
            mpend = 0;
        end
    endtask

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input logic v, input logic [23:0] d, input logic t, input logic s);
        in_valid = v; in_data = d; tick = t; out_strobe = s;
        m_edge(v, d, t, s);
        @(negedge clk);
        in_valid = 0; tick = 0; out_strobe = 0;
    endtask

    task automatic ticks(input int n);
        for (int j = 0; j < n; j++) cyc(0, 24'd0, 1, 0);
    endtask

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_model(input string tag);
        chk({tag, " u0 data"}, longint'($signed(out_d0)), longint'(mout[0]));
        chk({tag, " u1 data"}, longint'($signed(out_d1)), longint'(mout[1]));
        chk({tag, " valid"},   longint'(out_v0), longint'(mvld));
        chk({tag, " overrun"}, longint'(ovr0),   longint'(movr));
    endtask

    task automatic do_reset();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        m_reset();
    endtask

    typedef struct packed {
        logic signed [23:0] samp;
        int                 nt;
        logic signed [23:0] exp1;
    } vec_t;

    // integrator instance: output is the running sum of sample*ticks
    localparam vec_t VECS [5] = '{
        '{24'sd100,   2, 24'sd200},
        '{-24'sd50,   3, 24'sd50},
        '{24'sd0,     1, 24'sd50},
        '{24'sd1000,  1, 24'sd1050},
        '{-24'sd2000, 1, -24'sd950}
    };

    initial begin
        mf0[0] = src_pkg::LP_FF0; mf1[0] = src_pkg::LP_FF1; mf2[0] = src_pkg::LP_FF2;
        mb1[0] = src_pkg::LP_FB1; mb2[0] = src_pkg::LP_FB2;
        mf0[1] = UNITY; mf1[1] = 0; mf2[1] = 0; mb1[1] = UNITY; mb2[1] = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        chk("R1 out_data", longint'(out_d0), 0);
        chk("R1 out_valid", longint'(out_v0), 0);
        chk("R1 overrun", longint'(ovr0), 0);
        cyc(0, 24'd0, 0, 1);
        chk("R1 strobe after reset data", longint'(out_d1), 0);
        chk("R6 valid after strobe", longint'(out_v1), 1);
        cyc(0, 24'd0, 0, 0);
        chk("R6 valid one cycle", longint'(out_v1), 0);

        // R2/R3/R5: table of vectors
        for (int k = 0; k < 5; k++) begin
            cyc(1, VECS[k].samp, 0, 0);
            ticks(VECS[k].nt);
            cyc(0, 24'd0, 0, 1);
            chk("R2 held sample sum", longint'($signed(out_d1)), longint'(VECS[k].exp1));
            chk_model("R3 R5 filter vector");
        end

        // R4: positive and negative saturation of the integrator
        cyc(1, 24'h7fffff, 0, 0);
        ticks(20);
        cyc(0, 24'd0, 0, 1);
        chk("R4 positive clip", longint'($signed(out_d1)), 8388607);
        chk_model("R4 model positive");
        ticks(1);
        cyc(0, 24'd0, 0, 1);
        chk("R4 no wrap", longint'($signed(out_d1)), 8388607);
        cyc(1, 24'h800000, 0, 0);
        ticks(40);
        cyc(0, 24'd0, 0, 1);
        chk("R4 negative clip", longint'($signed(out_d1)), -8388608);
        chk_model("R4 model negative");

        // R6: no strobe -> output holds while filter moves
        do_reset();
        cyc(1, 24'd7, 0, 0);
        ticks(1);
        cyc(0, 24'd0, 0, 1);
        chk("R6 strobe load", longint'(out_d1), 7);
        ticks(3);
        chk("R6 hold without strobe", longint'(out_d1), 7);
        chk("R6 valid low", longint'(out_v1), 0);

        // R7: strobe coinciding with tick uses pre-update value
        cyc(0, 24'd0, 1, 1);
        chk("R7 pre-update value", longint'(out_d1), 28);
        cyc(0, 24'd0, 0, 1);
        chk("R7 updated value next", longint'(out_d1), 35);
        cyc(0, 24'd0, 0, 1);
        chk("R3 no tick no change", longint'(out_d1), 35);
        chk_model("R3 model hold");

        // R8: overrun and same-edge sample/tick
        do_reset();
        cyc(1, 24'd10, 0, 0);
        chk("R8 single sample no flag", longint'(ovr1), 0);
        cyc(1, 24'd30, 0, 0);
        chk("R8 overrun set", longint'(ovr1), 1);
        ticks(1);
        cyc(0, 24'd0, 0, 1);
        chk("R8 newer sample kept", longint'(out_d1), 30);
        cyc(1, 24'd5, 1, 0);
        cyc(0, 24'd0, 0, 1);
        chk("R8 same-edge tick uses old", longint'(out_d1), 60);
        ticks(1);
        cyc(0, 24'd0, 0, 1);
        chk("R8 new sample used next tick", longint'(out_d1), 65);
        chk("R8 sticky flag", longint'(ovr1), 1);
        chk_model("R8 model");
        do_reset();
        chk("R8 reset clears flag", longint'(ovr1), 0);

        // R9: default low-pass DC response
        cyc(1, 24'h400000, 0, 0);
        ticks(400);
        cyc(0, 24'd0, 0, 1);
        begin
            longint diff;
            diff = longint'($signed(out_d0)) - 64'sd4194304;
            if (diff < 0) diff = -diff;
            chk("R9 DC within 4 LSB", (diff <= 4) ? 1 : 0, 1);
        end
        chk_model("R9 model");

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule